// File: doc/BRIEF.md
# Predicated Vector Single-to-Bfloat16 Narrowing Converter

This block takes a vector of IEEE single-precision lanes and narrows every selected lane to a bfloat16 value. The result stays in the same 32-bit lane position: the bfloat16 pattern fills the low 16 bits and the high 16 bits are cleared. A per-byte predicate decides which lanes take part. Lanes that are not selected either keep the old destination contents or are cleared, and the instruction word picks which of the two behaviours applies.

The block decodes a 32-bit instruction word. Two fixed opcode patterns are accepted: one selects merging and one selects zeroing. The decoder also extracts three register index fields for the surrounding register file. Any other word is flagged as undefined, and the destination is then passed through unchanged. The vector width is a parameter. An optional output register stage lets a full vector complete on every clock.

Top module: `vcvt_bf16_pred`

## Requirements
- R1: For each active lane, bits [15:0] of the lane hold the bfloat16 value of the FP32 input, rounded to nearest with ties to even at bit 16, and bits [31:16] of the lane are zero.
- R2: An exact tie rounds towards an even bfloat16 mantissa. A rounding carry out of the largest finite magnitude produces infinity of the same sign (0x7F80 or 0xFF80).
- R3: A NaN input (exponent 0xFF, non-zero mantissa) produces {sign, 0xFF, 1, input mantissa bits [21:16]}, which is a quiet NaN.
- R4: An infinity or a zero input keeps its sign and becomes the matching bfloat16 infinity or zero.
- R5: A denormal input (exponent 0, non-zero mantissa) gives a signed zero when `flush_den` is 1. When `flush_den` is 0 it is rounded like a normal value, so 0x007FFFFF becomes 0x0080.
- R6: In merging mode, an inactive lane keeps the value of the matching lane of `old_dst`.
- R7: In zeroing mode, an inactive lane is all zeros.
- R8: Lane L is active exactly when `pred[4*L]` is 1. The other three predicate bits of each lane have no effect.
- R9: When `insn[31:13]` is 0110010110001010101 the block uses merging mode. When `insn[31:13]` is 0110010010011010110 it uses zeroing mode.
- R10: `pg_idx`, `zn_idx` and `zd_idx` show `insn[12:10]`, `insn[9:5]` and `insn[4:0]` respectively.
- R11: When `insn[31:13]` matches neither pattern, `undef` is 1 and `res_vec` equals `old_dst`. Otherwise `undef` is 0.
- R12: With OUT_REG=1, the results of a vector sampled with `in_valid` high appear, with `res_valid` high, exactly one cycle later. A cycle without `in_valid` gives `res_valid` low one cycle later. Reset clears `res_valid`, `undef` and `res_vec`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A vector operation is presented this cycle |
| insn | input | 32 | Instruction word to decode |
| src_vec | input | VLEN | Source FP32 lanes |
| old_dst | input | VLEN | Previous destination contents |
| pred | input | VLEN/8 | Predicate, one bit per byte |
| flush_den | input | 1 | Flush denormal inputs to signed zero |
| res_valid | output | 1 | Result outputs are valid |
| res_vec | output | VLEN | Converted destination vector |
| undef | output | 1 | Instruction word was not recognised |
| pg_idx | output | 3 | Governing predicate register index |
| zn_idx | output | 5 | Source vector register index |
| zd_idx | output | 5 | Destination vector register index |

## Verification
With the default OUT_REG=1, every output of an operation is due one clock after the edge that samples `in_valid`: the converted vector, the undefined flag and the three indices. The driver records the cycle number when it queues each expected item. The monitor samples on the falling edge and compares only while `res_valid` is high, and it checks that each popped item is exactly one cycle old. After an idle cycle the monitor also confirms that `res_valid` has dropped.

// File: rtl/vcvt_bf16_pkg.sv
package vcvt_bf16_pkg;

  localparam logic [18:0] OPC_MERGE = 19'b0110010110001010101;
  localparam logic [18:0] OPC_ZERO  = 19'b0110010010011010110;

  typedef struct packed {
    logic       undef;
    logic       zero_mode;
    logic [2:0] pg;
    logic [4:0] zn;
    logic [4:0] zd;
  } dec_t;

  // FP32 -> bfloat16, round to nearest even, optional denormal flush
  function automatic logic [15:0] bf16_from_fp32(input logic [31:0] x, input logic ftz);
    logic [7:0]  ex;
    logic        man_nz;
    logic        rnd;
    logic [15:0] r;
    ex     = x[30:23];
    man_nz = |x[22:0];
    rnd    = 1'b0;
    if (ex == 8'hFF && man_nz)
      r = {x[31], 8'hFF, 1'b1, x[21:16]};
    else if (ex == 8'hFF)
      r = {x[31], 8'hFF, 7'h00};
    else if (ex == 8'h00 && (ftz || !man_nz))
      r = {x[31], 15'h0000};
    else begin
      rnd = x[15] & (x[16] | (|x[14:0]));
      r   = x[31:16] + {15'h0000, rnd};
    end
    return r;
  endfunction

endpackage

// File: rtl/nc_insn_decode.sv
module nc_insn_decode
  import vcvt_bf16_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);
  logic hit_merge;
  logic hit_zero;

  assign hit_merge = (insn[31:13] == OPC_MERGE);
  assign hit_zero  = (insn[31:13] == OPC_ZERO);

  always_comb begin
    dec.undef     = !(hit_merge || hit_zero);
    dec.zero_mode = hit_zero;
    dec.pg        = insn[12:10];
    dec.zn        = insn[9:5];
    dec.zd        = insn[4:0];
  end
endmodule

// File: rtl/nc_lane_cvt.sv
module nc_lane_cvt
  import vcvt_bf16_pkg::*;
(
  input  logic [31:0] fp_in,
  input  logic        flush,
  output logic [15:0] bf_out
);
  assign bf_out = bf16_from_fp32(fp_in, flush);
endmodule

// File: rtl/nc_lane_pred.sv
module nc_lane_pred (
  input  logic [15:0] cvt,
  input  logic [31:0] old_lane,
  input  logic        act,
  input  logic        zero_mode,
  input  logic        hold,
  output logic [31:0] lane_out
);
  always_comb begin
    if (hold)           lane_out = old_lane;
    else if (act)       lane_out = {16'h0000, cvt};
    else if (zero_mode) lane_out = 32'h0000_0000;
    else                lane_out = old_lane;
  end
endmodule

// File: rtl/vcvt_bf16_pred.sv
module vcvt_bf16_pred
  import vcvt_bf16_pkg::*;
#(
  parameter int VLEN    = 128,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       insn,
  input  logic [VLEN-1:0]   src_vec,
  input  logic [VLEN-1:0]   old_dst,
  input  logic [VLEN/8-1:0] pred,
  input  logic              flush_den,
  output logic              res_valid,
  output logic [VLEN-1:0]   res_vec,
  output logic              undef,
  output logic [2:0]        pg_idx,
  output logic [4:0]        zn_idx,
  output logic [4:0]        zd_idx
);
  localparam int LANES = VLEN / 32;
  localparam int PW    = VLEN / 8;

  dec_t            dec;
  logic            dec_undef;
  logic [LANES-1:0] lane_act;
  logic [VLEN-1:0] comb_vec;
  logic            unused_pred;

  // observation wires (output-side view)
  logic [LANES-1:0] out_act;
  logic            out_zero;
  logic [VLEN-1:0] out_old;

  nc_insn_decode u_dec (.insn(insn), .dec(dec));
  assign dec_undef = dec.undef;
  assign unused_pred = ^pred;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [15:0] bf;
    assign lane_act[l] = pred[4*l];
    nc_lane_cvt u_cvt (
      .fp_in (src_vec[32*l +: 32]),
      .flush (flush_den),
      .bf_out(bf)
    );
    nc_lane_pred u_sel (
      .cvt      (bf),
      .old_lane (old_dst[32*l +: 32]),
      .act      (lane_act[l]),
      .zero_mode(dec.zero_mode),
      .hold     (dec.undef),
      .lane_out (comb_vec[32*l +: 32])
    );
  end

  if (OUT_REG) begin : g_reg
    logic [VLEN-1:0]  vec_q;
    logic [VLEN-1:0]  old_q;
    logic [LANES-1:0] act_q;
    logic             zero_q;
    logic             und_q;
    logic             vld_q;
    logic [2:0]       pg_q;
    logic [4:0]       zn_q;
    logic [4:0]       zd_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q  <= '0;
        old_q  <= '0;
        act_q  <= '0;
        zero_q <= 1'b0;
        und_q  <= 1'b0;
        vld_q  <= 1'b0;
        pg_q   <= '0;
        zn_q   <= '0;
        zd_q   <= '0;
      end else begin
        vld_q <= in_valid;
        und_q <= in_valid & dec.undef;
        if (in_valid) begin
          vec_q  <= comb_vec;
          old_q  <= old_dst;
          act_q  <= lane_act;
          zero_q <= dec.zero_mode;
          pg_q   <= dec.pg;
          zn_q   <= dec.zn;
          zd_q   <= dec.zd;
        end
      end
    end

    assign res_valid = vld_q;
    assign res_vec   = vec_q;
    assign undef     = und_q;
    assign pg_idx    = pg_q;
    assign zn_idx    = zn_q;
    assign zd_idx    = zd_q;
    assign out_act   = act_q;
    assign out_zero  = zero_q;
    assign out_old   = old_q;
  end else begin : g_comb
    assign res_valid = in_valid;
    assign res_vec   = comb_vec;
    assign undef     = in_valid & dec.undef;
    assign pg_idx    = dec.pg;
    assign zn_idx    = dec.zn;
    assign zd_idx    = dec.zd;
    assign out_act   = lane_act;
    assign out_zero  = dec.zero_mode;
    assign out_old   = old_dst;
  end

endmodule

// File: rtl/vcvt_bf16_chk.sv
module vcvt_bf16_chk #(
  parameter int VLEN    = 128,
  parameter bit OUT_REG = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 dec_undef,
  input logic                 res_valid,
  input logic                 undef,
  input logic [VLEN-1:0]      res_vec,
  input logic [VLEN/32-1:0]   out_act,
  input logic                 out_zero,
  input logic [VLEN-1:0]      out_old
);
  localparam int LANES = VLEN / 32;

  logic [VLEN-1:0] hi_act;
  logic [VLEN-1:0] inact;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      hi_act[32*l +: 32] = {{16{out_act[l]}}, 16'h0000};
      inact[32*l +: 32]  = {32{~out_act[l]}};
    end
  end

  a_r1_hi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !undef) |-> ((res_vec & hi_act) == '0));

  a_r7_zero_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !undef && out_zero) |-> ((res_vec & inact) == '0));

  a_r6_merge_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !undef && !out_zero) |-> ((res_vec & inact) == (out_old & inact)));

  a_r11_undef_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && undef) |-> (res_vec == out_old));

  if (OUT_REG) begin : g_seq
    a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);
    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid);
    a_r11_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dec_undef) |=> undef);
  end else begin : g_imm
    always_comb begin
      if (rst_n && in_valid) begin
        a_r11_flag_c: assert (undef == dec_undef);
      end
    end
  end
endmodule

bind vcvt_bf16_pred vcvt_bf16_chk #(.VLEN(VLEN), .OUT_REG(OUT_REG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .dec_undef(dec_undef),
  .res_valid(res_valid),
  .undef    (undef),
  .res_vec  (res_vec),
  .out_act  (out_act),
  .out_zero (out_zero),
  .out_old  (out_old)
);

// File: tb/sim_vcvt_bf16_pred.sv
module sim_vcvt_bf16_pred;
  localparam int VLEN  = 128;
  localparam int LANES = VLEN / 32;
  localparam int PW    = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [31:0]     insn = '0;
  logic [VLEN-1:0] src_vec = '0;
  logic [VLEN-1:0] old_dst = '0;
  logic [PW-1:0]   pred = '0;
  logic            flush_den = 1'b0;
  logic            res_valid;
  logic [VLEN-1:0] res_vec;
  logic            undef;
  logic [2:0]      pg_idx;
  logic [4:0]      zn_idx;
  logic [4:0]      zd_idx;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [VLEN-1:0] q_res[$];
  logic [13:0]     q_misc[$];
  int              q_cyc[$];
  string           q_tag[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vcvt_bf16_pred #(.VLEN(VLEN), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .src_vec(src_vec), .old_dst(old_dst), .pred(pred), .flush_den(flush_den),
    .res_valid(res_valid), .res_vec(res_vec), .undef(undef),
    .pg_idx(pg_idx), .zn_idx(zn_idx), .zd_idx(zd_idx)
  );

  // reference conversion: bias-add formulation
  function automatic logic [15:0] ref_bf(input logic [31:0] x, input logic ftz);
    logic [32:0] s;
    if (x[30:23] == 8'hFF) begin
      if (x[22:0] != 0) return (x[31:16] & 16'h803F) | 16'h7FC0;
      return x[31:16];
    end
    if (x[30:23] == 8'h00 && (ftz || x[22:0] == 0)) return {x[31], 15'h0};
    s = {1'b0, x} + 33'h7FFF + {32'h0, x[16]};
    return s[31:16];
  endfunction

  function automatic logic [31:0] mk(input bit zmode, input logic [2:0] pg,
                                     input logic [4:0] zn, input logic [4:0] zd);
    logic [18:0] top;
    top = zmode ? 19'b0110010010011010110 : 19'b0110010110001010101;
    return {top, pg, zn, zd};
  endfunction

  task automatic fail(input string tag, input string what);
    n_bad++;
    $display("FAIL %s: %s", tag, what);
  endtask

  task automatic drive(input logic [31:0] w, input logic [VLEN-1:0] s,
                       input logic [VLEN-1:0] o, input logic [PW-1:0] p,
                       input logic ftz, input string tag);
    logic [VLEN-1:0] e;
    logic is_m, is_z, und;
    @(negedge clk);
    in_valid = 1'b1; insn = w; src_vec = s; old_dst = o; pred = p; flush_den = ftz;
    is_m = (w[31:13] == 19'b0110010110001010101);
    is_z = (w[31:13] == 19'b0110010010011010110);
    und  = !(is_m || is_z);
    for (int l = 0; l < LANES; l++) begin
      if (und)               e[32*l +: 32] = o[32*l +: 32];
      else if (p[4*l])       e[32*l +: 32] = {16'h0, ref_bf(s[32*l +: 32], ftz)};
      else if (is_z)         e[32*l +: 32] = '0;
      else                   e[32*l +: 32] = o[32*l +: 32];
    end
    q_res.push_back(e);
    q_misc.push_back({und, w[12:0]});
    q_cyc.push_back(cyc);
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q_res.size() == 0) begin
        n_cmp++;
        fail("R12", "res_valid high with nothing expected (act 1 exp 0)");
      end else begin
        logic [VLEN-1:0] e;
        logic [13:0] m;
        int c;
        string t;
        e = q_res.pop_front(); m = q_misc.pop_front();
        c = q_cyc.pop_front(); t = q_tag.pop_front();
        n_cmp++;
        if (res_vec !== e || undef !== m[13])
          fail(t, $sformatf("res %h undef %b exp res %h undef %b", res_vec, undef, e, m[13]));
        n_cmp++;
        if ({pg_idx, zn_idx, zd_idx} !== m[12:0])
          fail("R10", $sformatf("idx %h exp %h", {pg_idx, zn_idx, zd_idx}, m[12:0]));
        n_cmp++;
        if (cyc != c + 1)
          fail("R12", $sformatf("latency %0d exp 1", cyc - c));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: run hung (act timeout exp finish)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    n_cmp++;
    if (res_valid !== 1'b0 || undef !== 1'b0 || res_vec !== '0)
      fail("R12", $sformatf("reset res_valid %b undef %b res %h exp 0 0 0", res_valid, undef, res_vec));
    @(negedge clk);
    rst_n = 1'b1;
    idle();

    // R1 basic rounding, all lanes active, merging form (R9)
    drive(mk(0, 3'd1, 5'd2, 5'd3),
          {32'h3F808000, 32'hC0200000, 32'h40490FDB, 32'h3F800000},
          {4{32'hDEADBEEF}}, {PW{1'b1}}, 1'b0, "R1");
    // R2 ties and overflow to infinity
    drive(mk(0, 3'd7, 5'd31, 5'd0),
          {32'hFF7FFFFF, 32'h7F7FFFFF, 32'h3F808001, 32'h3F818000},
          '0, {PW{1'b1}}, 1'b0, "R2");
    // R3 NaN quieting, R4 inf/zero
    drive(mk(1, 3'd0, 5'd5, 5'd9),
          {32'h80000000, 32'h7F800000, 32'hFFC00001, 32'h7FA12345},
          '0, {PW{1'b1}}, 1'b0, "R3");
    drive(mk(0, 3'd2, 5'd1, 5'd1),
          {32'hFF800000, 32'h00000000, 32'h7F800000, 32'h80000000},
          '0, {PW{1'b1}}, 1'b0, "R4");
    // R5 denormal flush and no flush
    drive(mk(0, 3'd3, 5'd4, 5'd6),
          {32'h007FFFFF, 32'h00000001, 32'h807FFFFF, 32'h00400000},
          '0, {PW{1'b1}}, 1'b1, "R5");
    drive(mk(0, 3'd3, 5'd4, 5'd6),
          {32'h007FFFFF, 32'h00000001, 32'h807FFFFF, 32'h00408000},
          '0, {PW{1'b1}}, 1'b0, "R5");
    // R6 merge with partial predicate (lanes 0 and 2)
    drive(mk(0, 3'd4, 5'd10, 5'd11),
          {32'h41200000, 32'h42C80000, 32'h3E99999A, 32'hBF000000},
          {32'h11112222, 32'h33334444, 32'h55556666, 32'h77778888},
          16'h0101, 1'b0, "R6");
    // R7 zeroing with same predicate
    drive(mk(1, 3'd4, 5'd10, 5'd11),
          {32'h41200000, 32'h42C80000, 32'h3E99999A, 32'hBF000000},
          {32'h11112222, 32'h33334444, 32'h55556666, 32'h77778888},
          16'h0101, 1'b0, "R7");
    // R8 only non-lowest predicate bits set: no lane active
    drive(mk(0, 3'd5, 5'd12, 5'd13),
          {4{32'h3F800000}}, {32'hAAAA0001, 32'hBBBB0002, 32'hCCCC0003, 32'hDDDD0004},
          16'hEEEE, 1'b0, "R8");
    drive(mk(1, 3'd5, 5'd12, 5'd13),
          {4{32'h3F800000}}, {32'hAAAA0001, 32'hBBBB0002, 32'hCCCC0003, 32'hDDDD0004},
          16'hE1E1, 1'b0, "R8");
    // R11 undefined words (one bit off each pattern)
    drive({19'b0110010110001010100, 13'h1ABC},
          {4{32'h3F800000}}, {32'h01020304, 32'h05060708, 32'h090A0B0C, 32'h0D0E0F10},
          {PW{1'b1}}, 1'b0, "R11");
    drive({19'b1110010010011010110, 13'h0155},
          {4{32'h40000000}}, {32'hCAFEF00D, 32'h0BADBEEF, 32'h12345678, 32'h9ABCDEF0},
          {PW{1'b1}}, 1'b0, "R11");
    // R9 zeroing form recognised, R10 indices
    drive(mk(1, 3'd6, 5'd21, 5'd26),
          {32'hC2F6E979, 32'h3DCCCCCD, 32'h47000000, 32'h3F7FFFFF},
          {4{32'hFFFFFFFF}}, 16'h1010, 1'b0, "R9");
    idle();
    @(negedge clk);
    // R12 idle cycle gives res_valid low
    n_cmp++;
    if (res_valid !== 1'b0)
      fail("R12", $sformatf("res_valid %b after idle exp 0", res_valid));
    n_cmp++;
    if (q_res.size() != 0)
      fail("R12", $sformatf("%0d results missing exp 0", q_res.size()));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule